// File: doc/BRIEF.md
# PLL Control and Status Register Block

This block is the register front end for an on-chip PLL and the clock-selection logic around it. It is an APB slave with zero wait states. It drives the PLL power-down line and a 3-bit multiplier code. It also holds the plain source and divisor words that the clock-selection logic reads from a flat output bus.

The multiplier code is taken from bootstrap pins while reset is held, so the PLL can run with a board-chosen ratio before any software has run. The two unused codes are replaced by the code for a 25 MHz input.

The PLL lock input is synchronized and shown live in the status word. A sticky flag records any falling edge of the lock input and stays set until software writes 1 to it.

Top module: `pllctl_regs`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0. Read data for a transfer is valid during its access phase.
- R2: While `rst` is high, the following are cleared: power-down, the lost-lock flag, every word on `sel_regs` and `prdata`.
- R3: During reset the multiplier code follows `strap_mult`, with codes 3'b000 and 3'b001 replaced by 3'b011. The value present in the last reset cycle is kept.
- R4: A write to offset 0x00 behaves as follows:
  - bit 31 is loaded into `pll_pwrdn`;
  - bits 2:0 are loaded verbatim into `pll_mult`;
  - a read of offset 0x00 returns {power-down, 28 zero bits, multiplier}.
- R5: Bit 0 of the status word at offset 0x04 shows the `pll_lock` level after a two-flop synchronizer.
- R6: Bit 1 of the status word is the lost-lock flag. It sets on a high-to-low transition of the synchronized lock, and it stays set when lock returns.
- R7: Writing a word with bit 1 = 1 to offset 0x04 clears the lost-lock flag. Writing a word with bit 1 = 0 leaves the flag unchanged.
- R8: If a falling lock edge and a clearing write happen in the same cycle, the flag ends up set.
- R9: Offsets 0x08 to 0x2C are ten read/write words. The word at offset 0x08+4k appears on `sel_regs[32k+31:32k]`.
- R10: Word offsets beyond 0x2C read as 0, and writes to them change no register.
- R11: Status bits 31:2 read as 0. A write to the status word changes neither the configuration word nor any plain word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_mult | input | 3 | Bootstrap multiplier code sampled during reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | APB ready, constant 1 |
| pslverr | output | 1 | APB error, constant 0 |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| pll_pwrdn | output | 1 | PLL power-down control |
| pll_mult | output | 3 | PLL multiplier code |
| sel_regs | output | 320 | Ten clock source/divisor words, flattened |

## Verification
A falling edge of the synchronized lock signal and a software write-1 clear can reach the sticky flag in the same cycle.

The bench drops `pll_lock` on a falling clock edge and starts a status write on the next falling edge. This puts the write's access edge exactly where the synchronized falling edge is detected. It then reads status and expects the flag still set.

A second run moves the write one cycle later and expects the flag cleared. This shows that the first result came from set priority and not from a missed clear.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;
  localparam int MULT_W         = 3;
  localparam int CFG_WORD_IDX   = 0;
  localparam int STS_WORD_IDX   = 1;
  localparam int FIRST_PLAIN_IX = 2;
  localparam logic [MULT_W-1:0] MULT_FALLBACK = 3'b011;

  // Strap codes 000 and 001 are not valid multipliers.
  function automatic logic [MULT_W-1:0] fix_strap(input logic [MULT_W-1:0] code);
    return (code[MULT_W-1:1] == '0) ? MULT_FALLBACK : code;
  endfunction
endpackage

// File: rtl/pllctl_lock_mon.sv
module pllctl_lock_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_in,
  input  logic clr_req,
  output logic lock_live,
  output logic lost_flag
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   live_d;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-2:0], lock_in};
  end

  assign lock_live = chain[SYNC_STAGES-1];
  assign fall      = live_d & ~lock_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_d    <= 1'b0;
      lost_flag <= 1'b0;
    end else begin
      live_d <= lock_live;
      if (fall)         lost_flag <= 1'b1;   // set has priority
      else if (clr_req) lost_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pllctl_apb_dec.sv
module pllctl_apb_dec #(
  parameter int ADDR_W    = 12,
  parameter int NUM_PLAIN = 10,
  parameter int PIDX_W    = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              acc_wr,
  output logic              rd_setup,
  output logic              is_cfg,
  output logic              is_sts,
  output logic              is_plain,
  output logic [PIDX_W-1:0] plain_idx
);
  import pllctl_pkg::*;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CFG_IX   = IDX_W'(CFG_WORD_IDX);
  localparam logic [IDX_W-1:0] STS_IX   = IDX_W'(STS_WORD_IDX);
  localparam logic [IDX_W-1:0] PLAIN_LO = IDX_W'(FIRST_PLAIN_IX);
  localparam logic [IDX_W-1:0] PLAIN_HI = IDX_W'(FIRST_PLAIN_IX + NUM_PLAIN);

  logic [IDX_W-1:0] word_idx;
  logic [IDX_W-1:0] rel_idx;
  logic             unused_lsb;

  assign word_idx   = paddr[ADDR_W-1:2];
  assign unused_lsb = ^paddr[1:0];
  assign rel_idx    = word_idx - PLAIN_LO;

  assign acc_wr    = psel & penable & pwrite;
  assign rd_setup  = psel & ~penable & ~pwrite;
  assign is_cfg    = (word_idx == CFG_IX);
  assign is_sts    = (word_idx == STS_IX);
  assign is_plain  = (word_idx >= PLAIN_LO) && (word_idx < PLAIN_HI);
  assign plain_idx = rel_idx[PIDX_W-1:0];
endmodule

// File: rtl/pllctl_plain_bank.sv
module pllctl_plain_bank #(
  parameter int NUM_PLAIN = 10,
  parameter int DATA_W    = 32,
  parameter int PIDX_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [PIDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NUM_PLAIN*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] store [NUM_PLAIN];

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                   store[g] <= '0;
      else if (wr_en && idx == PIDX_W'(g))       store[g] <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = store[g];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_PLAIN; k++)
      if (idx == PIDX_W'(k)) rdata = store[k];
  end
endmodule

// File: rtl/pllctl_regs.sv
module pllctl_regs #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int NUM_PLAIN   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0]                  strap_mult,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [DATA_W-1:0]           pwdata,
  output logic [DATA_W-1:0]           prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic                        pll_lock,
  output logic                        pll_pwrdn,
  output logic [2:0]                  pll_mult,
  output logic [NUM_PLAIN*DATA_W-1:0] sel_regs
);
  import pllctl_pkg::*;
  localparam int PIDX_W = (NUM_PLAIN > 1) ? $clog2(NUM_PLAIN) : 1;

  logic              acc_wr, rd_setup, is_cfg, is_sts, is_plain;
  logic [PIDX_W-1:0] plain_idx;
  logic [DATA_W-1:0] plain_rdata;
  logic [DATA_W-1:0] rd_word;
  logic              lock_live, lost_flag;

  pllctl_apb_dec #(.ADDR_W(ADDR_W), .NUM_PLAIN(NUM_PLAIN), .PIDX_W(PIDX_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .acc_wr(acc_wr), .rd_setup(rd_setup), .is_cfg(is_cfg), .is_sts(is_sts),
    .is_plain(is_plain), .plain_idx(plain_idx)
  );

  pllctl_lock_mon #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .clk(clk), .rst(rst), .lock_in(pll_lock),
    .clr_req(acc_wr & is_sts & pwdata[1]),
    .lock_live(lock_live), .lost_flag(lost_flag)
  );

  pllctl_plain_bank #(.NUM_PLAIN(NUM_PLAIN), .DATA_W(DATA_W), .PIDX_W(PIDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(acc_wr & is_plain), .idx(plain_idx),
    .wdata(pwdata), .rdata(plain_rdata), .flat(sel_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_pwrdn <= 1'b0;
      pll_mult  <= fix_strap(strap_mult);
    end else if (acc_wr && is_cfg) begin
      pll_pwrdn <= pwdata[DATA_W-1];
      pll_mult  <= pwdata[MULT_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (is_cfg) begin
      rd_word[DATA_W-1]   = pll_pwrdn;
      rd_word[MULT_W-1:0] = pll_mult;
    end else if (is_sts) begin
      rd_word[1] = lost_flag;
      rd_word[0] = lock_live;
    end else if (is_plain) begin
      rd_word = plain_rdata;
    end
  end

  // Captured in the setup phase so the data is stable for the access phase.
  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_word;
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/pllctl_regs_chk.sv
module pllctl_regs_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_PLAIN = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              pll_pwrdn,
  input logic [2:0]        pll_mult,
  input logic              lock_live,
  input logic              lost_flag
);
  localparam int NUM_WORDS = 2 + NUM_PLAIN;
  logic [31:0] widx;
  logic        wr_acc, wr_sts, wr_cfg, clr_try, rd_unmapped;

  assign widx        = 32'(paddr[ADDR_W-1:2]);
  assign wr_acc      = psel && penable && pwrite;
  assign wr_sts      = wr_acc && widx == 32'd1;
  assign wr_cfg      = wr_acc && widx == 32'd0;
  assign clr_try     = wr_sts && pwdata[1];
  assign rd_unmapped = psel && !penable && !pwrite && widx >= 32'(NUM_WORDS);

  p_no_error_r1: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr);

  p_strap_valid_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pll_mult[2:1] != 2'b00);

  p_pwrdn_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> pll_pwrdn == $past(pwdata[DATA_W-1]));

  p_fall_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (!lock_live && $past(lock_live)) |=> lost_flag);

  p_flag_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (lost_flag && !clr_try) |=> lost_flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_try && !(!lock_live && $past(lock_live))) |=> !lost_flag);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rd_unmapped |=> prdata == '0);
endmodule

bind pllctl_regs pllctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PLAIN(NUM_PLAIN)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
  .pslverr(pslverr), .pll_pwrdn(pll_pwrdn), .pll_mult(pll_mult),
  .lock_live(lock_live), .lost_flag(lost_flag)
);

// File: tb/tb_pllctl_regs.sv
module tb_pllctl_regs;
  localparam int ADDR_W = 12, DATA_W = 32, NUM_PLAIN = 10;

  logic clk = 0, rst = 1;
  logic [2:0] strap_mult = 0;
  logic psel = 0, penable = 0, pwrite = 0, pll_lock = 0;
  logic [ADDR_W-1:0] paddr = 0;
  logic [DATA_W-1:0] pwdata = 0, prdata;
  logic pready, pslverr, pll_pwrdn;
  logic [2:0] pll_mult;
  logic [NUM_PLAIN*DATA_W-1:0] sel_regs;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pllctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PLAIN(NUM_PLAIN)) dut (
    .clk(clk), .rst(rst), .strap_mult(strap_mult), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pll_lock(pll_lock),
    .pll_pwrdn(pll_pwrdn), .pll_mult(pll_mult), .sel_regs(sel_regs)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk);
    @(negedge clk); penable = 1;
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk);
    @(negedge clk); penable = 1;
    #1;
    chk(pready === 1'b1 && pslverr === 1'b0, "R1", {pready, pslverr}, 2'b10);
    d = prdata;
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk); rst = 1; strap_mult = s;
    repeat (3) @(negedge clk);
    rst = 0; strap_mult = ~s;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rd, expw;
    logic [NUM_PLAIN*DATA_W-1:0] snap;

    // R2 / R3: strap sweep over all codes
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      expw = (s < 2) ? 32'd3 : 32'(s);
      chk(pll_mult == expw[2:0], "R3 mult out", 64'(pll_mult), 64'(expw[2:0]));
      chk(pll_pwrdn == 1'b0 && sel_regs == '0, "R2 reset outputs", 64'(pll_pwrdn), 0);
      chk(prdata == '0, "R2 prdata", 64'(prdata), 0);
      apb_rd(12'h000, rd);
      chk(rd == expw, "R3 cfg read", 64'(rd), 64'(expw));
      apb_rd(12'h004, rd);
      chk(rd == 32'd0, "R2 status after reset", 64'(rd), 0);
    end

    // R4: config write sweep, reserved bits written as ones
    for (int c = 0; c < 16; c++) begin
      logic pd;
      logic [2:0] code;
      pd = c[3];
      code = c[2:0];
      apb_wr(12'h000, {pd, 28'hFFFFFFF, code});
      chk(pll_pwrdn == pd && pll_mult == code, "R4 outputs", 64'({pll_pwrdn, pll_mult}), 64'({pd, code}));
      apb_rd(12'h000, rd);
      expw = {pd, 28'd0, code};
      chk(rd == expw, "R4 readback", 64'(rd), 64'(expw));
    end

    // R5 / R6 / R7
    pll_lock = 1; wait_cyc(4);
    apb_rd(12'h004, rd);
    chk(rd == 32'd1, "R5 live lock high", 64'(rd), 1);
    pll_lock = 0; wait_cyc(4);
    apb_rd(12'h004, rd);
    chk(rd == 32'd2, "R6 fall sets flag", 64'(rd), 2);
    pll_lock = 1; wait_cyc(4);
    apb_rd(12'h004, rd);
    chk(rd == 32'd3, "R6 flag sticky over relock", 64'(rd), 3);
    apb_wr(12'h004, 32'hFFFF_FFFD);
    apb_rd(12'h004, rd);
    chk(rd == 32'd3, "R7 write 0 keeps flag", 64'(rd), 3);
    chk(pll_pwrdn == 1'b1 && pll_mult == 3'd7 && sel_regs == '0, "R11 status write isolated",
        64'({pll_pwrdn, pll_mult}), 64'hF);
    apb_wr(12'h004, 32'h0000_0002);
    apb_rd(12'h004, rd);
    chk(rd == 32'd1, "R7 write 1 clears", 64'(rd), 1);
    chk(rd[31:2] == '0, "R11 reserved status zero", 64'(rd), 1);

    // R8: fall and clear in the same cycle
    @(negedge clk); pll_lock = 0;
    apb_wr(12'h004, 32'h0000_0002);
    wait_cyc(3);
    apb_rd(12'h004, rd);
    chk(rd == 32'd2, "R8 set wins over clear", 64'(rd), 2);
    // Clear one cycle after the fall is detected
    pll_lock = 1; wait_cyc(4);
    apb_wr(12'h004, 32'h0000_0002);
    @(negedge clk); pll_lock = 0;
    @(negedge clk);
    apb_wr(12'h004, 32'h0000_0002);
    wait_cyc(3);
    apb_rd(12'h004, rd);
    chk(rd == 32'd0, "R8 later clear removes flag", 64'(rd), 0);

    // R9: plain words
    for (int k = 0; k < NUM_PLAIN; k++)
      apb_wr(12'(8 + 4 * k), 32'h1357_9BDF ^ (32'(k) * 32'h0101_0101));
    for (int k = 0; k < NUM_PLAIN; k++) begin
      expw = 32'h1357_9BDF ^ (32'(k) * 32'h0101_0101);
      apb_rd(12'(8 + 4 * k), rd);
      chk(rd == expw, "R9 plain readback", 64'(rd), 64'(expw));
      chk(sel_regs[k*DATA_W +: DATA_W] == expw, "R9 plain bus", 64'(sel_regs[k*DATA_W +: DATA_W]), 64'(expw));
    end

    // R10: unmapped offsets
    snap = sel_regs;
    for (int u = 0; u < 4; u++) begin
      logic [ADDR_W-1:0] a;
      a = (u == 3) ? 12'hFFC : 12'(12'h030 + 4 * u);
      apb_wr(a, 32'hFFFF_FFFF);
      apb_rd(a, rd);
      chk(rd == '0, "R10 unmapped read zero", 64'(rd), 0);
    end
    chk(sel_regs == snap, "R10 unmapped write ignored", 64'(sel_regs[63:0]), 64'(snap[63:0]));
    apb_rd(12'h000, rd);
    chk(rd == 32'h8000_0007, "R10 cfg untouched", 64'(rd), 64'h8000_0007);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule